// File: doc/BRIEF.md
# Peripheral DMA Channel Transfer Sequencer

This block is the engine of one DMA channel. Once enabled, it moves a programmed number of data items between a peripheral address and a memory address, in the direction selected by a control bit. Items can be 1, 2 or 4 bytes wide. Each address either advances by the item size after every item or stays fixed. Every item is moved by two accesses on one request/grant bus master port: a read from the source, then a write of the same data to the destination. Unless memory-to-memory mode is selected, each item waits for the peripheral request line before it starts.

The item count counts down live. That count, and the remaining byte count derived from it, are presented on the ports so that software can read them. The channel raises single-cycle event pulses at the half-way point, at completion and on a bus error. In circular mode the count and both addresses reload themselves when the count reaches zero, and the channel keeps running. Outside circular mode, the channel parks after completion or after an error until its enable is dropped. When enable is raised again, fresh addresses and a fresh count are loaded.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, busy_o, req_o, half_o, done_o and err_o are low and count_o is zero.
- R2: With dir_i=1 each item is read from the memory address and written to the peripheral address. With dir_i=0 it is read from the peripheral address and written to the memory address. The written data equals the data returned by the read.
- R3: Size code size_i 0/1/2 selects a 1/2/4-byte item, and code 3 behaves as 4 bytes. An address whose increment bit (pinc_i for the peripheral, minc_i for memory) is 1 advances by the item size after each item. An address whose increment bit is 0 stays fixed.
- R4: count_o starts at count_i and drops by one when each item's write is granted. rem_bytes_o equals count_o shifted left by the size code, with code 3 shifting by 2.
- R5: With m2m_i=0, no item starts its read while preq_i is low. With m2m_i=1, preq_i is ignored.
- R6: done_o pulses for one cycle, in the cycle after the last item's write grant. Outside circular mode the channel then stops: busy_o and req_o stay low until en_i is deasserted and asserted again.
- R7: half_o pulses exactly once per pass, after the item whose write takes the count to count_i/2 rounded down.
- R8: With circ_i=1, reaching zero reloads the count and both addresses from their inputs. busy_o stays high and done_o pulses once per pass.
- R9: An err_i response on a granted access pulses err_o and stops the channel at once. No further requests are made.
- R10: Deasserting en_i aborts the transfer. A later enable restarts from the current count_i, paddr_i and maddr_i.
- R11: Enabling with count_i equal to zero starts no transfer.
- R12: While req_o is high and gnt_i is low, req_o, we_o and addr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable (level) |
| dir_i | input | 1 | 1: memory to peripheral, 0: peripheral to memory |
| circ_i | input | 1 | Circular auto-reload mode |
| pinc_i | input | 1 | Peripheral address increment |
| minc_i | input | 1 | Memory address increment |
| m2m_i | input | 1 | Ignore peripheral request |
| size_i | input | 2 | Item size code |
| count_i | input | 16 | Programmed item count |
| paddr_i | input | 32 | Peripheral start address |
| maddr_i | input | 32 | Memory start address |
| preq_i | input | 1 | Peripheral request |
| req_o | output | 1 | Bus access request |
| we_o | output | 1 | Bus write (1) or read (0) |
| addr_o | output | 32 | Bus address |
| wdata_o | output | 32 | Bus write data |
| gnt_i | input | 1 | Bus grant; completes the access |
| err_i | input | 1 | Bus error, valid with gnt_i |
| rdata_i | input | 32 | Bus read data, valid with gnt_i |
| busy_o | output | 1 | Transfer in progress |
| count_o | output | 16 | Live remaining item count |
| rem_bytes_o | output | 18 | Remaining bytes |
| half_o | output | 1 | Half-transfer pulse |
| done_o | output | 1 | Transfer-complete pulse |
| err_o | output | 1 | Transfer-error pulse |

## Verification
Randomized transfers vary direction, item size (including the spare code 3), both increment bits and odd and even counts. Bus grants are delayed at random, so that address sequencing, data forwarding and the half-way point can be told apart across all combinations. Directed runs cover cases that random stimulus rarely reaches. Circular passes with counts of 3 and 1 show the reload and the repeated done and half pulses. A held-low peripheral request separates paced from free-running transfers. An injected bus error, an abort followed by a re-enable at a new address, and a zero count probe the stop paths.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_HALT} seq_st_e;

  function automatic logic [1:0] shift_of(logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction

  function automatic logic [2:0] step_of(logic [1:0] sz);
    return 3'd1 << shift_of(sz);
  endfunction
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] start_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= start_i;
    else if (adv_i)  addr_q <= addr_q + AW'(step_i);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_item_cnt.sv
module dma_item_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic [CW-1:0] start_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          half_o
);
  logic [CW-1:0] cnt_q, thr_q;
  logic          half_seen_q;

  assign last_o = (cnt_q == CW'(1));
  assign half_o = dec_i && !half_seen_q && ((cnt_q - CW'(1)) == thr_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      thr_q       <= '0;
      half_seen_q <= 1'b0;
    end else if (load_i) begin
      cnt_q       <= start_i;
      thr_q       <= start_i >> 1;
      half_seen_q <= 1'b0;
    end else if (dec_i) begin
      cnt_q <= cnt_q - CW'(1);
      if (half_o) half_seen_q <= 1'b1;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i |-> cnt_q != '0); // R4
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dir_i,
  input  logic          circ_i,
  input  logic          pinc_i,
  input  logic          minc_i,
  input  logic          m2m_i,
  input  logic [1:0]    size_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [AW-1:0] maddr_i,
  input  logic          preq_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          gnt_i,
  input  logic          err_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic [CW-1:0] count_o,
  output logic [CW+1:0] rem_bytes_o,
  output logic          half_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int RW = CW + 2;
  localparam int NA = 2;  // 0: peripheral, 1: memory

  seq_st_e       st_q, st_d;
  logic [DW-1:0] data_q;
  logic          done_q, half_q, err_q;
  logic          start, rd_ok, wr_ok, bus_err, last, half_hit, reload, ld;
  logic [AW-1:0] addr_v  [NA];
  logic [AW-1:0] start_v [NA];
  logic          inc_v   [NA];
  logic [2:0]    step;

  assign step       = step_of(size_i);
  assign start_v[0] = paddr_i;
  assign start_v[1] = maddr_i;
  assign inc_v[0]   = pinc_i;
  assign inc_v[1]   = minc_i;

  assign start   = (st_q == ST_IDLE) && en_i && (count_i != '0);
  assign rd_ok   = (st_q == ST_RD) && gnt_i && !err_i;
  assign wr_ok   = (st_q == ST_WR) && gnt_i && !err_i;
  assign bus_err = ((st_q == ST_RD) || (st_q == ST_WR)) && gnt_i && err_i;
  assign reload  = wr_ok && last && circ_i;
  assign ld      = start || reload;

  for (genvar i = 0; i < NA; i++) begin : g_addr
    dma_addr_gen #(.AW(AW)) i_addr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (ld),
      .adv_i   (wr_ok && inc_v[i]),
      .step_i  (step),
      .start_i (start_v[i]),
      .addr_o  (addr_v[i])
    );
  end

  dma_item_cnt #(.CW(CW)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ld),
    .dec_i   (wr_ok),
    .start_i (count_i),
    .cnt_o   (count_o),
    .last_o  (last),
    .half_o  (half_hit)
  );

  always_comb begin
    st_d = st_q;
    if (!en_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: if (start) st_d = ST_WAIT;
        ST_WAIT: if (m2m_i || preq_i) st_d = ST_RD;
        ST_RD:   if (bus_err) st_d = ST_HALT;
                 else if (rd_ok) st_d = ST_WR;
        ST_WR:   if (bus_err) st_d = ST_HALT;
                 else if (wr_ok) st_d = (last && !circ_i) ? ST_HALT : ST_WAIT;
        default: st_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      done_q <= 1'b0;
      half_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= wr_ok && last;
      half_q <= wr_ok && half_hit;
      err_q  <= bus_err;
      if (rd_ok) data_q <= rdata_i;
    end
  end

  // source is memory when dir_i is set
  assign req_o       = (st_q == ST_RD) || (st_q == ST_WR);
  assign we_o        = (st_q == ST_WR);
  assign addr_o      = we_o ? addr_v[dir_i ? 0 : 1] : addr_v[dir_i ? 1 : 0];
  assign wdata_o     = data_q;
  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_HALT);
  assign rem_bytes_o = RW'(count_o) << shift_of(size_i);
  assign half_o      = half_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i && en_i |=> req_o && $stable(addr_o) && $stable(we_o)); // R12
  AST_ERR_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_o && !busy_o); // R9
  AST_PREQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) && ($past(st_q) == ST_WAIT) |-> $past(preq_i || m2m_i)); // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_o && we_o && gnt_i)); // R6
  AST_PULSE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  logic clk = 0, rst_ni = 0;
  logic en_i = 0, dir_i = 0, circ_i = 0, pinc_i = 0, minc_i = 0, m2m_i = 0, preq_i = 0;
  logic [1:0] size_i = 0;
  logic [15:0] count_i = 0;
  logic [31:0] paddr_i = 0, maddr_i = 0;
  logic req_o, we_o, gnt_i = 0, err_i = 0;
  logic [31:0] addr_o, wdata_o, rdata_i = 0;
  logic busy_o, half_o, done_o, err_o;
  logic [15:0] count_o;
  logic [17:0] rem_bytes_o;

  int checks = 0, errors = 0;
  logic [31:0] wa [256], wd [256];
  logic [15:0] wc [256];
  logic [17:0] wr_rem [256];
  int wr_n, rd_n, done_n, half_n, err_n, half_at, hold_bad;
  bit err_arm = 0, prev_pend = 0;
  logic [31:0] prev_addr;

  always #2 clk = ~clk;

  dma_chan_seq i_dma_chan_seq (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .dir_i(dir_i), .circ_i(circ_i),
    .pinc_i(pinc_i), .minc_i(minc_i), .m2m_i(m2m_i), .size_i(size_i), .count_i(count_i),
    .paddr_i(paddr_i), .maddr_i(maddr_i), .preq_i(preq_i), .req_o(req_o), .we_o(we_o),
    .addr_o(addr_o), .wdata_o(wdata_o), .gnt_i(gnt_i), .err_i(err_i), .rdata_i(rdata_i),
    .busy_o(busy_o), .count_o(count_o), .rem_bytes_o(rem_bytes_o), .half_o(half_o),
    .done_o(done_o), .err_o(err_o));

  function automatic logic [31:0] patt(logic [31:0] a);
    return a ^ 32'h5A3C_9E11;
  endfunction

  function automatic int step_b(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_n = 0; rd_n = 0; done_n = 0; half_n = 0; err_n = 0; half_at = -1;
  endtask

  // bus responder and event monitor
  initial begin
    clear_logs();
    hold_bad = 0;
    forever begin
      @(negedge clk);
      if (prev_pend && req_o && addr_o != prev_addr) hold_bad++;
      if (done_o) done_n++;
      if (half_o) begin
        if (half_n == 0) half_at = wr_n;
        half_n++;
      end
      if (err_o) err_n++;
      if (req_o && ($urandom % 4 != 0)) begin
        gnt_i = 1;
        rdata_i = patt(addr_o);
        err_i = err_arm;
        err_arm = 0;
        if (!err_i && we_o && wr_n < 256) begin
          wa[wr_n] = addr_o; wd[wr_n] = wdata_o; wc[wr_n] = count_o; wr_rem[wr_n] = rem_bytes_o;
          wr_n++;
        end else if (!err_i && !we_o) rd_n++;
        prev_pend = 0;
      end else begin
        gnt_i = 0; err_i = 0;
        prev_pend = req_o;
        prev_addr = addr_o;
      end
    end
  end

  task automatic setup(bit d, logic [1:0] sz, bit pi, bit mi, bit mm, bit ci,
                       logic [15:0] n, logic [31:0] pa, logic [31:0] ma);
    @(negedge clk);
    dir_i = d; size_i = sz; pinc_i = pi; minc_i = mi; m2m_i = mm; circ_i = ci;
    count_i = n; paddr_i = pa; maddr_i = ma;
    clear_logs();
  endtask

  task automatic run_xfer(bit d, logic [1:0] sz, bit pi, bit mi, bit mm, bit ci,
                          logic [15:0] n, logic [31:0] pa, logic [31:0] ma, int passes);
    int t = 0;
    int st = step_b(sz);
    logic [31:0] rb, wb, ra, wx;
    setup(d, sz, pi, mi, mm, ci, n, pa, ma);
    preq_i = 1;
    en_i = 1;
    while (done_n < passes && t < 20000) begin @(posedge clk); t++; end
    @(negedge clk);
    if (ci) chk(busy_o == 1, "R8", "busy after pass", busy_o, 1);
    else begin
      repeat (5) @(negedge clk);
      chk(busy_o == 0 && req_o == 0, "R6", "stopped after done", {busy_o, req_o}, 0);
      chk(wr_n == n, "R6", "items written", wr_n, n);
      chk(done_n == 1, "R6", "done pulses", done_n, 1);
    end
    chk(half_n == passes, "R7", "half pulses", half_n, passes);
    chk(half_at == n - n / 2, "R7", "half position", half_at, n - n / 2);
    rb = d ? ma : pa; wb = d ? pa : ma;
    for (int k = 0; k < passes * n && k < wr_n; k++) begin
      int idx = k % n;
      ra = rb + (((d ? mi : pi)) ? 32'(idx * st) : 0);
      wx = wb + (((d ? pi : mi)) ? 32'(idx * st) : 0);
      chk(wa[k] == wx, "R3", "write address", wa[k], wx);
      chk(wd[k] == patt(ra), "R2", "write data/source", wd[k], patt(ra));
      chk(wc[k] == 16'(n - idx), "R4", "live count", wc[k], n - idx);
      chk(wr_rem[k] == 18'((n - idx) * st), "R4", "remaining bytes", wr_rem[k], (n - idx) * st);
    end
    en_i = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int snap;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!busy_o && !req_o && !half_o && !done_o && !err_o && count_o == 0, "R1", "reset state",
        {busy_o, req_o, half_o, done_o, err_o, count_o}, 0);

    // directed mixes
    run_xfer(1, 2'd2, 0, 1, 0, 0, 16'd6, 32'h4000_0010, 32'h8000_0100, 1);
    run_xfer(0, 2'd0, 1, 1, 1, 0, 16'd7, 32'h4000_0021, 32'h8000_0203, 1);
    run_xfer(0, 2'd3, 0, 1, 0, 0, 16'd1, 32'h4000_0040, 32'h8000_0400, 1);
    for (int r = 0; r < 10; r++)
      run_xfer($urandom % 2, 2'($urandom % 4), $urandom % 2, $urandom % 2, $urandom % 2, 0,
               16'(1 + $urandom % 12), $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, 1);
    // circular
    run_xfer(1, 2'd1, 1, 1, 0, 1, 16'd3, 32'h4000_0100, 32'h8000_1000, 2);
    run_xfer(0, 2'd2, 0, 1, 1, 1, 16'd1, 32'h4000_0200, 32'h8000_2000, 3);

    // R5: peripheral request gating
    setup(0, 2'd2, 0, 1, 0, 0, 16'd2, 32'h4000_0300, 32'h8000_3000);
    preq_i = 0; en_i = 1;
    repeat (20) @(negedge clk);
    chk(rd_n == 0 && !req_o, "R5", "no access without preq", rd_n, 0);
    chk(count_o == 2 && busy_o, "R5", "waiting with count held", count_o, 2);
    preq_i = 1;
    repeat (40) @(negedge clk);
    chk(wr_n == 2, "R5", "proceeds after preq", wr_n, 2);
    en_i = 0; repeat (3) @(negedge clk);

    // R9: bus error
    setup(1, 2'd2, 1, 1, 1, 0, 16'd5, 32'h4000_0400, 32'h8000_4000);
    err_arm = 1; en_i = 1;
    repeat (30) @(negedge clk);
    chk(err_n == 1, "R9", "error pulse", err_n, 1);
    chk(!busy_o && !req_o && wr_n == 0, "R9", "stopped after error", {busy_o, req_o, wr_n}, 0);
    chk(count_o == 5, "R9", "count frozen", count_o, 5);
    en_i = 0; repeat (3) @(negedge clk);

    // R10: abort and restart at a new buffer
    setup(1, 2'd2, 0, 1, 1, 0, 16'd40, 32'h4000_0500, 32'h8000_5000);
    en_i = 1;
    while (wr_n < 3) @(negedge clk);
    en_i = 0;
    @(negedge clk);
    snap = wr_n;
    repeat (10) @(negedge clk);
    chk(wr_n == snap && !busy_o && !req_o, "R10", "abort stops writes", wr_n, snap);
    setup(0, 2'd2, 0, 1, 1, 0, 16'd2, 32'h4000_0600, 32'h8000_6000);
    en_i = 1;
    repeat (40) @(negedge clk);
    chk(wr_n == 2, "R10", "restart count", wr_n, 2);
    chk(wa[0] == 32'h8000_6000, "R10", "restart address", wa[0], 32'h8000_6000);
    en_i = 0; repeat (3) @(negedge clk);

    // R11: zero count
    setup(0, 2'd0, 1, 1, 1, 0, 16'd0, 32'h4000_0700, 32'h8000_7000);
    en_i = 1;
    repeat (10) @(negedge clk);
    chk(!busy_o && rd_n == 0 && !req_o, "R11", "zero count idle", {busy_o, req_o}, 0);
    en_i = 0; repeat (3) @(negedge clk);

    chk(hold_bad == 0, "R12", "request held stable", hold_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule